// File: doc/BRIEF.md
# Gray-Coded Difference Signature Builder

This block turns a stream of per-challenge oscillation count pairs into a fixed-length device signature. For each accepted challenge it subtracts the second bank's count from the first, keeping a 16-bit two's-complement result. It then Gray-encodes that result and extracts the bit positions named by a selection mask, which may name one, two or three positions. The extracted bits are written into the signature at the current fill position, lowest mask index first. The fill position then advances by the number of bits written.

A small state machine has two states. `ST_FILL` accepts challenges. The transition *complete* goes to `ST_FULL` when the write that lands on the last signature position happens. `ST_FULL` raises signature-valid and ignores further challenges. The transition *clear* comes from the clear input and returns from either state to `ST_FILL`, with an empty signature and a fill position of zero. A challenge whose mask names no positions, or more than three, is refused and reported on an error flag.

Top module: `diffsig_builder`

## Requirements
- R1: After reset, `signature` is all zero, `sig_valid` is low and `cfg_err` is low.
- R2: The value coded for a challenge is d = (`cnt_a` − `cnt_b`) mod 2^16, with bit 15 as its sign. Its Gray code is g = d XOR (d >> 1). For example, d = 31 gives g bit 4 = 1 and bit 5 = 0, while d = 32 gives bit 4 = 1 and bit 5 = 1.
- R3: Each accepted challenge emits g[i] for every set bit i of `pick_mask`, in ascending order of i.
- R4: The first emitted bit of a challenge goes to `signature[p]`, where p is the fill position (the total number of bits written since the last reset or clear), and the following emitted bits go to p+1 and p+2. The first challenge after a clear therefore fills `signature[0]` upward.
- R5: Bits that would land at position 128 or beyond are dropped. `sig_valid` goes high on the clock edge that writes position 127 and is visible in the cycle that follows.
- R6: While `sig_valid` is high, `in_valid` has no effect and `signature` holds its value.
- R7: When `clr` is high at a clock edge, it zeroes `signature`, sets the fill position to 0 and lowers `sig_valid`. It takes priority over an `in_valid` in the same cycle.
- R8: If `in_valid` comes with a `pick_mask` that has zero set bits or more than three, nothing is written and the fill position does not move. `cfg_err` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the signature and fill position |
| in_valid | input | 1 | A count pair for one challenge is present this cycle |
| cnt_a | input | 16 | Oscillation count from bank one |
| cnt_b | input | 16 | Oscillation count from bank two |
| pick_mask | input | 16 | Positions of the Gray-coded difference to emit |
| signature | output | 128 | Signature under construction; bit 0 is the first bit written |
| sig_valid | output | 1 | Signature is complete and frozen |
| cfg_err | output | 1 | Previous challenge was refused because of a bad mask |

## Verification
The bench builds the block with its default parameters: 16-bit counts, a 128-bit signature and at most three picks per challenge. At that size, every fill length is reached: 128 one-bit challenges, 64 two-bit challenges, and 43 three-bit challenges whose last challenge loses one bit to the drop rule.

A sweep walks the mask across all sixteen single positions while the count pairs vary, including pairs where the second count is larger, so the sign bit and every Gray position are compared against an arithmetic model. Refused masks, challenges arriving while the signature is full, and a clear arriving together with a challenge are each checked at the outputs.

// File: rtl/diffsig_pkg.sv
package diffsig_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/diffsig_gray.sv
module diffsig_gray #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    output logic [CNT_W-1:0] gray
);
    logic [CNT_W-1:0] diff;

    assign diff = cnt_a - cnt_b;
    assign gray[CNT_W-1] = diff[CNT_W-1];

    for (genvar i = 0; i < CNT_W - 1; i++) begin : g_code
        assign gray[i] = diff[i] ^ diff[i+1];
    end
endmodule

// File: rtl/diffsig_pick.sv
module diffsig_pick #(
    parameter int CNT_W = 16,
    parameter int NPICK = 3,
    localparam int CW   = $clog2(CNT_W + 1)
) (
    input  logic [CNT_W-1:0] gray,
    input  logic [CNT_W-1:0] mask,
    output logic [NPICK-1:0] bits,
    output logic [CW-1:0]    count,
    output logic             legal
);
    int n;

    always_comb begin
        bits = '0;
        n    = 0;
        for (int i = 0; i < CNT_W; i++) begin
            if (mask[i]) begin
                if (n < NPICK) begin
                    bits[n] = gray[i];
                end
                n = n + 1;
            end
        end
        count = n[CW-1:0];
        legal = (n >= 1) && (n <= NPICK);
    end
endmodule

// File: rtl/diffsig_builder.sv
module diffsig_builder #(
    parameter int CNT_W = 16,
    parameter int SIG_W = 128,
    parameter int NPICK = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [15:0]      cnt_a,
    input  logic [15:0]      cnt_b,
    input  logic [15:0]      pick_mask,
    output logic [127:0]     signature,
    output logic             sig_valid,
    output logic             cfg_err
);
    import diffsig_pkg::*;

    localparam int FW = $clog2(SIG_W + 1);
    localparam int CW = $clog2(CNT_W + 1);

    fill_state_e      state_q, state_d;
    logic [SIG_W-1:0] sig_q;
    logic [FW-1:0]    fill_q, fill_d;
    logic             err_q;
    logic [CNT_W-1:0] gray;
    logic [NPICK-1:0] pick_bits;
    logic [CW-1:0]    pick_cnt;
    logic             pick_ok;
    logic             accept;
    int               room, take;

    diffsig_gray #(.CNT_W(CNT_W)) u_gray (
        .cnt_a (cnt_a[CNT_W-1:0]),
        .cnt_b (cnt_b[CNT_W-1:0]),
        .gray  (gray)
    );

    diffsig_pick #(.CNT_W(CNT_W), .NPICK(NPICK)) u_pick (
        .gray  (gray),
        .mask  (pick_mask[CNT_W-1:0]),
        .bits  (pick_bits),
        .count (pick_cnt),
        .legal (pick_ok)
    );

    assign accept = in_valid && pick_ok && (state_q == ST_FILL);

    always_comb begin
        room   = SIG_W - int'(fill_q);
        take   = (int'(pick_cnt) < room) ? int'(pick_cnt) : room;
        fill_d = fill_q + take[FW-1:0];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (!clr && accept && (int'(fill_d) == SIG_W)) state_d = ST_FULL;
            ST_FULL: if (clr) state_d = ST_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // signature storage and fill position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q  <= '0;
            fill_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= in_valid && !pick_ok && !clr;
            if (clr) begin
                sig_q  <= '0;
                fill_q <= '0;
            end else if (accept) begin
                for (int k = 0; k < NPICK; k++) begin
                    if (k < int'(pick_cnt) && (int'(fill_q) + k) < SIG_W) begin
                        sig_q[int'(fill_q) + k] <= pick_bits[k];
                    end
                end
                fill_q <= fill_d;
            end
        end
    end

    // outputs
    always_comb begin
        signature = '0;
        signature[SIG_W-1:0] = sig_q;
        sig_valid = (state_q == ST_FULL);
        cfg_err   = err_q;
    end
endmodule

// File: rtl/diffsig_builder_chk.sv
module diffsig_builder_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         in_valid,
    input logic [15:0]  pick_mask,
    input logic [127:0] signature,
    input logic         sig_valid,
    input logic         cfg_err
);
    logic bad_mask;
    assign bad_mask = ($countones(pick_mask) == 0) || ($countones(pick_mask) > 3);

    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_valid && !clr) |=> ($stable(signature) && sig_valid));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!sig_valid && signature == '0));

    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_mask && !clr) |=> cfg_err);

    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_mask && !clr) |=> $stable(signature));

    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(in_valid));

    a_r5_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_valid) |-> ($past(in_valid) && !$past(clr)));
endmodule

bind diffsig_builder diffsig_builder_chk u_diffsig_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .pick_mask (pick_mask),
    .signature (signature),
    .sig_valid (sig_valid),
    .cfg_err   (cfg_err)
);

// File: tb/test_diffsig_builder.sv
module test_diffsig_builder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         in_valid = 1'b0;
    logic [15:0]  cnt_a = '0;
    logic [15:0]  cnt_b = '0;
    logic [15:0]  pick_mask = '0;
    logic [127:0] signature;
    logic         sig_valid;
    logic         cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [127:0] exp_sig  = '0;
    int           exp_fill = 0;
    bit           exp_full = 1'b0;
    bit           exp_err  = 1'b0;

    always #10 clk = ~clk;

    diffsig_builder i_diffsig_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (in_valid),
        .cnt_a     (cnt_a),
        .cnt_b     (cnt_b),
        .pick_mask (pick_mask),
        .signature (signature),
        .sig_valid (sig_valid),
        .cfg_err   (cfg_err)
    );

    task automatic check_all(input string tag);
        n_checks++;
        if (signature !== exp_sig || sig_valid !== exp_full || cfg_err !== exp_err) begin
            n_fail++;
            $display("FAIL %s: sig=%h valid=%0b err=%0b expected sig=%h valid=%0b err=%0b",
                     tag, signature, sig_valid, cfg_err, exp_sig, exp_full, exp_err);
        end
    endtask

    task automatic model_clear();
        exp_sig  = '0;
        exp_fill = 0;
        exp_full = 1'b0;
        exp_err  = 1'b0;
    endtask

    task automatic chal(input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] m, input string tag);
        logic [15:0] d, g;
        int          nb;
        @(negedge clk);
        cnt_a = a; cnt_b = b; pick_mask = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        d  = a - b;
        g  = d ^ (d >> 1);
        nb = $countones(m);
        exp_err = (nb == 0) || (nb > 3);
        if (!exp_err && !exp_full) begin
            for (int i = 0; i < 16; i++) begin
                if (m[i] && exp_fill < 128) begin
                    exp_sig[exp_fill] = g[i];
                    exp_fill++;
                end
            end
            if (exp_fill == 128) exp_full = 1'b1;
        end
        check_all(tag);
    endtask

    task automatic do_clear(input bool_with_valid);
        @(negedge clk);
        clr = 1'b1;
        in_valid = bool_with_valid;
        cnt_a = 16'h1234; cnt_b = 16'h0001; pick_mask = 16'h8000;
        @(negedge clk);
        clr = 1'b0;
        in_valid = 1'b0;
        model_clear();
        check_all("R7 clear");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset release");

        // R5 R4: sign bit only, 128 challenges, valid exactly on the last
        for (int i = 0; i < 128; i++) begin
            chal(16'(i * 977), 16'(i * 1531 + 7), 16'h8000, "R4 R5 sign-bit fill");
        end

        // R6: challenges while full are ignored
        for (int i = 0; i < 4; i++) begin
            chal(16'(i * 3 + 40000), 16'(i), 16'h0007, "R6 ignored while full");
        end

        do_clear(1'b0);

        // R3 R5: three bits per challenge, last challenge drops one bit
        for (int i = 0; i < 43; i++) begin
            chal(16'(i * 611 + 3), 16'(i * 389 + 1000), 16'h8060, "R3 R5 three-bit fill");
        end

        // R7: clear arriving with a challenge wins
        do_clear(1'b1);

        // R8: refused masks
        chal(16'd100, 16'd5, 16'h0000, "R8 empty mask");
        chal(16'd100, 16'd5, 16'h000F, "R8 four-bit mask");
        chal(16'd200, 16'd9, 16'hFFFF, "R8 full mask");
        chal(16'd7, 16'd3, 16'h8000, "R8 legal after refuse");
        do_clear(1'b0);

        // R2: neighbouring differences 31 and 32
        chal(16'd31, 16'd0, 16'h0030, "R2 diff 31");
        chal(16'd40, 16'd8, 16'h0030, "R2 diff 32");
        n_checks++;
        if (signature[3:0] !== 4'b1101) begin
            n_fail++;
            $display("FAIL R2 gray 31/32: got %b expected %b", signature[3:0], 4'b1101);
        end

        // R4 R5: two bits per challenge to fill
        for (int i = 0; i < 62; i++) begin
            chal(16'(i * 2003 + 11), 16'(i * 4099), 16'h8020, "R4 R5 two-bit fill");
        end

        do_clear(1'b0);

        // R2 R3: sweep every single position with varied count pairs
        for (int j = 0; j < 128; j++) begin
            chal(16'(j * 7919 + 5), 16'(j * 104729 + 13), 16'(1 << (j % 16)), "R2 R3 position sweep");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule